// File: doc/BRIEF.md
# Microcode ROM Handoff Sequencer

This block sits in an instruction front end between a stream of decoded micro-ops and the execution logic. Most instructions arrive fully expanded in the stream. Long or complex instructions do not. For each of those, the stream carries a single tag micro-op that names the entry address of a routine held in an on-chip microcode ROM.

When a tag is taken from the head of the stream, the sequencer stops accepting stream micro-ops. It then plays the ROM routine from that entry, one word per cycle. It goes back to the stream after it has loaded the word that carries the end-of-routine flag.

Both sources feed one registered output with a valid/ready handshake, and the output carries no source indication. A flush input drops whatever is pending and returns the sequencer to stream mode. The ROM contents are computed from a function at elaboration time.

Top module: `ucode_merge_seq`

## Requirements
- R1: While reset is held and after its release, `out_valid` is 0 and `in_ready` is 1 when `flush` is 0.
- R2: A stream micro-op accepted with `in_tag`=0 appears unchanged on `out_uop`, with `out_valid`=1, one cycle after the accepting clock edge. Accepted micro-ops leave in acceptance order.
- R3: A micro-op accepted with `in_tag`=1 is never forwarded. Its bits `in_uop[4:0]` give the ROM entry address, and `out_valid` is 0 in the cycle after it is accepted.
- R4: The first ROM micro-op of a routine is on the output in the second cycle after the tag's accepting edge, provided no flush occurs.
- R5: ROM word `a` holds micro-op `16'hA000 | a`. Its end-of-routine flag is set when `a[1:0]`=3 or `a`=31. A routine entered at `e` delivers words `e`, `e+1`, … up to and including the first word whose flag is set.
- R6: While a ROM routine is active, `in_ready` is 0. Once the flagged word has been loaded into the output, stream acceptance resumes.
- R7: While `out_valid`=1 and `out_ready`=0, `out_uop` stays stable and `out_valid` stays 1. No micro-op from either source is lost or duplicated.
- R8: A cycle with `flush`=1 accepts no stream input (`in_ready`=0). In the next cycle `out_valid`=0, the ROM routine is abandoned, and stream acceptance is possible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Abandon any routine and clear the output |
| in_valid | input | 1 | Stream micro-op present |
| in_ready | output | 1 | Stream micro-op accepted this cycle if valid |
| in_tag | input | 1 | Marks the stream micro-op as a ROM tag |
| in_uop | input | 16 | Stream micro-op, or entry address in low bits when tagged |
| out_valid | output | 1 | Merged micro-op present |
| out_ready | input | 1 | Consumer takes the merged micro-op |
| out_uop | output | 16 | Merged micro-op |

## Verification
Each result has a fixed due cycle, and every check samples at the falling edge of the cycle in which its result is due:
- A stream micro-op is due one cycle after its accepting edge.
- The empty output slot after a tag is due one cycle after the tag's accepting edge.
- The first ROM word is due two cycles after that edge.
- The cleared output after a flush is due one cycle after the flush edge.

Under random backpressure the bench records every handshake just after the falling edge. It expands tags with its own ROM model into a queue of expected micro-ops, compares each output handshake with the head of that queue, and checks after a drain that nothing is left over.

// File: rtl/ums_pkg.sv
package ums_pkg;
  parameter int UOP_W = 16;
  parameter int ROM_AW = 5;
  parameter int GROUP_AW = 2;
  parameter logic [UOP_W-1:0] ROM_BASE = 16'hA000;
  localparam int ROM_DEPTH = 1 << ROM_AW;

  typedef struct packed {
    logic             eos;
    logic [UOP_W-1:0] uop;
  } rom_word_t;

  function automatic rom_word_t rom_word(input logic [ROM_AW-1:0] a);
    rom_word_t w;
    w.uop = ROM_BASE | UOP_W'(a);
    w.eos = (&a[GROUP_AW-1:0]) || (a == ROM_AW'(ROM_DEPTH - 1));
    return w;
  endfunction
endpackage

// File: rtl/ums_rom.sv
module ums_rom
  import ums_pkg::*;
(
  input  logic [ROM_AW-1:0] addr,
  output rom_word_t         word
);
  rom_word_t table_q [ROM_DEPTH];

  for (genvar i = 0; i < ROM_DEPTH; i++) begin : g_word
    assign table_q[i] = rom_word(ROM_AW'(i));
  end

  assign word = table_q[addr];
endmodule

// File: rtl/ums_ctrl.sv
module ums_ctrl
  import ums_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              can_load,
  input  logic              tag_take,
  input  logic [ROM_AW-1:0] tag_entry,
  input  logic              rom_eos,
  output logic              mode_rom,
  output logic [ROM_AW-1:0] pc,
  output logic              rom_fire,
  output logic              seq_done
);
  assign rom_fire = mode_rom && can_load && !flush;
  assign seq_done = rom_fire && rom_eos;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_rom <= 1'b0;
      pc       <= '0;
    end else if (flush) begin
      mode_rom <= 1'b0;
    end else if (tag_take) begin
      mode_rom <= 1'b1;
      pc       <= tag_entry;
    end else if (rom_fire) begin
      if (rom_eos) mode_rom <= 1'b0;
      else         pc       <= pc + 1'b1;
    end
  end
endmodule

// File: rtl/ums_outreg.sv
module ums_outreg
  import ums_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             load,
  input  logic             load_valid,
  input  logic [UOP_W-1:0] load_uop,
  output logic             out_valid,
  output logic [UOP_W-1:0] out_uop
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_uop   <= '0;
    end else if (flush) begin
      out_valid <= 1'b0;
    end else if (load) begin
      out_valid <= load_valid;
      if (load_valid) out_uop <= load_uop;
    end
  end
endmodule

// File: rtl/ucode_merge_seq.sv
module ucode_merge_seq
  import ums_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_tag,
  input  logic [UOP_W-1:0] in_uop,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [UOP_W-1:0] out_uop
);
  logic              can_load;
  logic              in_fire;
  logic              tag_take;
  logic              uop_take;
  logic              mode_rom;
  logic              rom_fire;
  logic              seq_done;
  logic [ROM_AW-1:0] pc;
  rom_word_t         rom_q;
  logic              load_valid;
  logic [UOP_W-1:0]  load_uop;

  assign can_load = !out_valid || out_ready;
  assign in_ready = !flush && !mode_rom && can_load;
  assign in_fire  = in_valid && in_ready;
  assign tag_take = in_fire && in_tag;
  assign uop_take = in_fire && !in_tag;

  assign load_valid = rom_fire || uop_take;
  assign load_uop   = mode_rom ? rom_q.uop : in_uop;

  ums_rom rom_i (
    .addr (pc),
    .word (rom_q)
  );

  ums_ctrl ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .can_load  (can_load),
    .tag_take  (tag_take),
    .tag_entry (in_uop[ROM_AW-1:0]),
    .rom_eos   (rom_q.eos),
    .mode_rom  (mode_rom),
    .pc        (pc),
    .rom_fire  (rom_fire),
    .seq_done  (seq_done)
  );

  ums_outreg out_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .load       (can_load),
    .load_valid (load_valid),
    .load_uop   (load_uop),
    .out_valid  (out_valid),
    .out_uop    (out_uop)
  );
endmodule

// File: rtl/ums_chk.sv
module ums_chk
  import ums_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             flush,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [UOP_W-1:0] out_uop,
  input logic             mode_rom,
  input logic             tag_take,
  input logic             seq_done
);
  AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |-> !out_valid); // R1
  AST_TAG_SWALLOWED: assert property (@(posedge clk) disable iff (!rst_n)
    tag_take |=> !out_valid); // R3
  AST_ROM_FIRST_DUE: assert property (@(posedge clk) disable iff (!rst_n)
    tag_take ##1 !flush |=> out_valid); // R4
  AST_TRACE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    mode_rom |-> !in_ready); // R6
  AST_RETURN_TRACE: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> !mode_rom); // R6
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !flush |=> out_valid && $stable(out_uop)); // R7
  AST_FLUSH_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !in_ready); // R8
  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !out_valid && !mode_rom); // R8
endmodule

bind ucode_merge_seq ums_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .flush     (flush),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_uop   (out_uop),
  .mode_rom  (mode_rom),
  .tag_take  (tag_take),
  .seq_done  (seq_done)
);

// File: tb/ucode_merge_seq_tb.sv
`timescale 1ns/1ps
module ucode_merge_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_tag = 1'b0;
  logic [15:0] in_uop = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] out_uop;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] exp_q [$];

  always #5 clk = ~clk;

  ucode_merge_seq dut_i (.*);

  function automatic logic [15:0] model_uop(input int a);
    return 16'hA000 + 16'(a);
  endfunction

  function automatic int model_last(input int e);
    return (e / 4) * 4 + 3;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(out_valid == 0, "R1 reset out_valid", 16'(out_valid), 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 0, "R1 after reset out_valid", 16'(out_valid), 16'h0);
    chk(in_ready == 1, "R1 after reset in_ready", 16'(in_ready), 16'h1);

    in_valid = 1; in_tag = 0; in_uop = 16'h1234;
    cyc();
    in_valid = 0;
    chk(out_valid && out_uop == 16'h1234, "R2 stream uop", out_uop, 16'h1234);
    cyc();

    in_valid = 1; in_tag = 1; in_uop = 16'h0006;
    cyc();
    in_valid = 0; in_tag = 0;
    #1;
    chk(out_valid == 0, "R3 tag not forwarded", 16'(out_valid), 16'h0);
    chk(in_ready == 0, "R6 stream blocked", 16'(in_ready), 16'h0);
    cyc();
    chk(out_valid && out_uop == model_uop(6), "R4 first ROM uop due", out_uop, model_uop(6));
    chk(in_ready == 0, "R6 stream blocked mid routine", 16'(in_ready), 16'h0);
    cyc();
    chk(out_valid && out_uop == model_uop(7), "R5 ROM next word", out_uop, model_uop(7));
    #1;
    chk(in_ready == 1, "R6 stream resumes after flagged word", 16'(in_ready), 16'h1);
    cyc();
    chk(out_valid == 0, "R5 routine ends at flag", 16'(out_valid), 16'h0);

    in_valid = 1; in_tag = 1; in_uop = 16'h000C;
    cyc();
    in_valid = 0; in_tag = 0; out_ready = 0;
    cyc();
    for (int k = 0; k < 3; k++) begin
      chk(out_valid && out_uop == model_uop(12), "R7 stalled output held", out_uop, model_uop(12));
      chk(in_ready == 0, "R7 stall blocks stream", 16'(in_ready), 16'h0);
      cyc();
    end
    out_ready = 1;
    #1;
    for (int a = 12; a <= 15; a++) begin
      chk(out_valid && out_uop == model_uop(a), "R7 no loss after stall", out_uop, model_uop(a));
      cyc();
    end
    chk(out_valid == 0, "R5 end of routine 12", 16'(out_valid), 16'h0);

    in_valid = 1; in_tag = 1; in_uop = 16'h0010;
    cyc();
    in_valid = 0; in_tag = 0;
    cyc();
    chk(out_uop == model_uop(16), "R4 routine 16 start", out_uop, model_uop(16));
    flush = 1;
    #1;
    chk(in_ready == 0, "R8 flush blocks input", 16'(in_ready), 16'h0);
    cyc();
    flush = 0;
    #1;
    chk(out_valid == 0, "R8 flush clears output", 16'(out_valid), 16'h0);
    chk(in_ready == 1, "R8 stream after flush", 16'(in_ready), 16'h1);
    in_valid = 1; in_uop = 16'h5555;
    cyc();
    in_valid = 0;
    chk(out_valid && out_uop == 16'h5555, "R8 routine abandoned", out_uop, 16'h5555);
    cyc();

    void'($urandom(32'd7));
    begin
      bit held = 0;
      for (int t = 0; t < 4000; t++) begin
        if (!held) begin
          in_valid = ($urandom % 4) != 0;
          in_tag   = ($urandom % 6) == 0;
          in_uop   = in_tag ? 16'($urandom % 32) : 16'($urandom);
        end
        out_ready = ($urandom % 10) < 7;
        if (t > 3950) in_valid = 0;
        #1;
        if (out_valid && out_ready) begin
          if (exp_q.size() == 0)
            chk(0, "R2 unexpected output", out_uop, 16'hFFFF);
          else begin
            logic [15:0] e;
            e = exp_q.pop_front();
            chk(out_uop == e, "R5 R7 merged stream order", out_uop, e);
          end
        end
        if (in_valid && in_ready) begin
          if (in_tag) begin
            for (int a = int'(in_uop); a <= model_last(int'(in_uop)); a++)
              exp_q.push_back(model_uop(a));
          end else begin
            exp_q.push_back(in_uop);
          end
          held = 0;
        end else begin
          held = in_valid;
        end
        cyc();
      end
      in_valid = 0; out_ready = 1;
      for (int t = 0; t < 40; t++) begin
        #1;
        if (out_valid && exp_q.size() != 0) begin
          logic [15:0] e;
          e = exp_q.pop_front();
          chk(out_uop == e, "R7 drain order", out_uop, e);
        end
        cyc();
      end
      chk(exp_q.size() == 0, "R7 nothing lost", 16'(exp_q.size()), 16'h0);
    end
    summary();
  end
endmodule